// File: doc/BRIEF.md
# Self-Sustaining Synapse Modulation Assembly

This block couples a presynaptic spike train to a postsynaptic neuron through a small fixed network of linear-leak integrate-and-fire neurons. There are no stored synaptic weights. Short-term potentiation, short-term depression, prolonged coupling and voltage-dependent gating are produced by a helper neuron with strong self-excitation. Once sustained presynaptic activity switches the helper on, it fires on every tick. Sparse pseudo-random inhibitory spikes eventually switch it off.

Every internal neuron updates on the same tick strobe. A spike emitted on one tick reaches its targets on the next tick. The presynaptic input, the external postsynaptic drive and the mode are sampled on the tick itself. The inhibition probability is a run-time input, so the average hold time of the helper can be tuned: small values give long persistence and large values give short persistence.

Top module: `syn_mod_assembly`

## Requirements
- R1: After reset, `post_spk` and `helper_active` are 0, all membranes are 0 and the random generator holds its seed 16'hACE1.
- R2: State and outputs change only on a clock edge where `tick` is 1. Edges where `tick` is 0 leave both outputs unchanged, whatever the other inputs are.
- R3: The helper membrane gains W_PH=2 for each accepted presynaptic spike and loses LEAK=1 per tick. The helper fires when its membrane reaches H_TH=8. With no inhibition it becomes active after exactly 8 consecutive presynaptic ticks, and not after 7.
- R4: An active helper adds W_SELF=16 to itself. With no inhibitory spike it stays active on every following tick, even with no presynaptic input.
- R5: An inhibitory spike occurs on a tick when the low 8 bits of the generator are less than `inh_prob`. It subtracts W_INH=32 from the helper, so the helper is inactive after that tick. With `inh_prob`=0 no inhibition ever occurs.
- R6: Mode 0 (potentiate): the postsynaptic neuron gets +3 per presynaptic spike and +6 while the helper is active.
- R7: Mode 1 (depress): the presynaptic spike gives +3 and an active helper gives -6. While the helper is active and there is no external drive, the postsynaptic neuron does not fire.
- R8: Mode 2 (prolonged): there is no direct presynaptic path. An active helper gives +9, so the postsynaptic neuron keeps firing each tick after presynaptic input stops.
- R9: Mode 3 (gated): a gate latch is set on the tick after the postsynaptic neuron fires, and it clears whenever the mode is not 3. Presynaptic spikes reach the helper only while the gate is set, and before that they have no effect. The helper gives +9 to the postsynaptic neuron.
- R10: The generator is a 16-bit shift register that advances once per tick as {x[14:0], x[15]^x[13]^x[12]^x[10]}. Each tick's inhibition decision uses the value from before the advance.
- R11: Each membrane loses LEAK=1 per tick and is clamped to the range 0..255. On reaching its threshold (postsynaptic P_TH=8), a neuron fires and resets to 0. Idle ticks never drive a membrane below 0.
- R12: `post_ext` adds 9 to the postsynaptic membrane, which makes it fire on that tick in every mode where no helper inhibition applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-step strobe; all neurons update when high |
| pre_spk | input | 1 | Presynaptic spike for this tick |
| post_ext | input | 1 | External excitatory drive to the postsynaptic neuron |
| mode | input | 2 | 0 potentiate, 1 depress, 2 prolonged, 3 gated |
| inh_prob | input | 8 | Inhibition threshold against the generator's low byte |
| post_spk | output | 1 | Postsynaptic spike from the last tick |
| helper_active | output | 1 | Helper neuron spike from the last tick |

## Verification
The bench uses the default weights and thresholds. With these values helper activation is an exact 8-tick count and depression is a guaranteed silence, so both can be checked by hand. An inhibition setting of 0 makes persistence fully deterministic, and 255 forces near-immediate extinction. A middle setting of 40, combined with modes that change every few dozen ticks, brings the random extinction, re-activation and gate clearing within reach of the per-clock reference model.

// File: rtl/syn_mod_assembly.sv
module syn_mod_assembly #(
  parameter int VW      = 8,
  parameter int PW      = 8,
  parameter int H_TH    = 8,
  parameter int P_TH    = 8,
  parameter int LEAK    = 1,
  parameter int W_PH    = 2,
  parameter int W_SELF  = 16,
  parameter int W_INH   = 32,
  parameter int W_DIR   = 3,
  parameter int W_POT   = 6,
  parameter int W_DEP   = 6,
  parameter int W_RELAY = 9,
  parameter int W_EXT   = 9,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pre_spk,
  input  logic          post_ext,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] inh_prob,
  output logic          post_spk,
  output logic          helper_active
);
  localparam int VMAX = (1 << VW) - 1;
  localparam logic [1:0] M_POT = 2'd0, M_DEP = 2'd1, M_PROL = 2'd2, M_GATE = 2'd3;

  logic [15:0]   rng;
  logic [VW-1:0] vh, vp;
  logic          hq, pq, gq;
  logic          inh, helper_in;
  int            dh, dp, hterm;
  logic [VW:0]   h_nx, p_nx;

  function automatic logic [VW:0] step(input logic [VW-1:0] v, input int d, input int th);
    int s;
    s = int'(v) + d;
    if (s < 0) s = 0;
    if (s > VMAX) s = VMAX;
    if (s >= th) return {1'b1, {VW{1'b0}}};
    return {1'b0, VW'(s)};
  endfunction

  assign inh       = tick && (rng[PW-1:0] < inh_prob);
  assign helper_in = (mode == M_GATE) ? (pre_spk & gq) : pre_spk;

  always_comb begin
    case (mode)
      M_POT:   hterm = hq ? W_POT : 0;
      M_DEP:   hterm = hq ? -W_DEP : 0;
      default: hterm = hq ? W_RELAY : 0;
    endcase
    dh = (helper_in ? W_PH : 0) + (hq ? W_SELF : 0) - (inh ? W_INH : 0) - LEAK;
    dp = (((mode == M_POT) || (mode == M_DEP)) && pre_spk ? W_DIR : 0)
         + hterm + (post_ext ? W_EXT : 0) - LEAK;
    h_nx = step(vh, dh, H_TH);
    p_nx = step(vp, dp, P_TH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng <= SEED;
      vh  <= '0;
      vp  <= '0;
      hq  <= 1'b0;
      pq  <= 1'b0;
      gq  <= 1'b0;
    end else if (tick) begin
      rng <= {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
      vh  <= h_nx[VW-1:0];
      hq  <= h_nx[VW];
      vp  <= p_nx[VW-1:0];
      pq  <= p_nx[VW];
      gq  <= (mode == M_GATE) && (gq || pq);
    end
  end

  assign post_spk      = pq;
  assign helper_active = hq;

  // R2
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(post_spk) && $stable(helper_active)));
  // R4
  helper_sustain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hq && !inh) |=> hq);
  // R5
  helper_quench_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && inh) |=> !hq);
  // R7
  depress_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == M_DEP && hq && !post_ext) |=> !post_spk);
  // R9
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == M_GATE && !gq && !hq) |=> !hq);
  // R9
  gate_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == M_GATE && pq) |=> gq);
endmodule

// File: tb/syn_mod_assembly_test.sv
module syn_mod_assembly_test;
  logic clk = 0, rst_n = 0, tick = 0, pre_spk = 0, post_ext = 0;
  logic [1:0] mode = 0;
  logic [7:0] inh_prob = 0;
  logic post_spk, helper_active;

  syn_mod_assembly uut (.clk(clk), .rst_n(rst_n), .tick(tick), .pre_spk(pre_spk),
    .post_ext(post_ext), .mode(mode), .inh_prob(inh_prob),
    .post_spk(post_spk), .helper_active(helper_active));

  always #2.5 clk = ~clk;

  int total = 0, fails = 0, cycles = 0;
  string phase = "R1";

  int m_rng, m_vh, m_vp, m_h, m_p, m_g;

  function automatic int clampv(input int s);
    if (s < 0) return 0;
    if (s > 255) return 255;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rng = 16'hACE1; m_vh = 0; m_vp = 0; m_h = 0; m_p = 0; m_g = 0;
    end else if (tick) begin
      int inh, hin, sh, sp, nh, np, ng, fb;
      inh = ((m_rng & 255) < inh_prob) ? 1 : 0;
      hin = (mode == 3) ? (pre_spk && m_g) : pre_spk;
      sh = clampv(m_vh + (hin ? 2 : 0) + (m_h ? 16 : 0) - (inh ? 32 : 0) - 1);
      sp = m_vp - 1 + (post_ext ? 9 : 0) + ((mode < 2 && pre_spk) ? 3 : 0);
      if (m_h) sp += (mode == 0) ? 6 : (mode == 1) ? -6 : 9;
      sp = clampv(sp);
      nh = (sh >= 8); np = (sp >= 8);
      ng = (mode == 3) && (m_g || m_p);
      m_vh = nh ? 0 : sh; m_vp = np ? 0 : sp;
      m_h = nh; m_p = np; m_g = ng;
      fb = ((m_rng >> 15) ^ (m_rng >> 13) ^ (m_rng >> 12) ^ (m_rng >> 10)) & 1;
      m_rng = ((m_rng << 1) | fb) & 16'hFFFF;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check({phase, " post_spk"}, post_spk, m_p);
      check({phase, " helper_active"}, helper_active, m_h);
    end
    if (cycles > 150000) begin
      fails++; total++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic do_tick(input logic p, input logic e);
    @(negedge clk); pre_spk = p; post_ext = e; tick = 1;
    @(negedge clk); tick = 0; pre_spk = 0; post_ext = 0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input logic p);
    for (int i = 0; i < n; i++) do_tick(p, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    phase = "R1";
    check("R1 reset post", post_spk, 0);
    check("R1 reset helper", helper_active, 0);

    phase = "R11"; mode = 0; inh_prob = 0;
    ticks(10, 0);
    ticks(3, 1);
    check("R11 no fire after 3 pre", post_spk, 0);
    do_tick(1, 0);
    check("R11 fire on 4th pre after idle clamp", post_spk, 1);

    do_reset();
    phase = "R3"; mode = 0; inh_prob = 0;
    ticks(7, 1);
    check("R3 helper off after 7", helper_active, 0);
    do_tick(1, 0);
    check("R3 helper on after 8", helper_active, 1);

    phase = "R6";
    ticks(4, 1);
    check("R6 potentiated post fires", post_spk, 1);

    phase = "R2";
    @(negedge clk); pre_spk = 1; post_ext = 1; mode = 1; inh_prob = 255;
    repeat (5) @(negedge clk);
    check("R2 helper held without tick", helper_active, 1);
    pre_spk = 0; post_ext = 0; mode = 0; inh_prob = 0;

    phase = "R4";
    ticks(50, 0);
    check("R4 helper persists", helper_active, 1);

    phase = "R7"; mode = 1;
    ticks(2, 1);
    for (int i = 0; i < 3; i++) begin
      do_tick(1, 0);
      check("R7 depressed post silent", post_spk, 0);
    end

    phase = "R8"; mode = 2;
    ticks(3, 0);
    check("R8 prolonged post fires", post_spk, 1);

    phase = "R5"; inh_prob = 255;
    ticks(30, 0);
    check("R5 helper extinguished", helper_active, 0);

    do_reset();
    phase = "R9"; mode = 3; inh_prob = 0;
    ticks(20, 1);
    check("R9 gated pre no helper", helper_active, 0);
    check("R9 gated pre no post", post_spk, 0);
    phase = "R12";
    do_tick(0, 1);
    check("R12 external drive fires post", post_spk, 1);
    phase = "R9";
    ticks(10, 1);
    check("R9 helper after gate opens", helper_active, 1);

    phase = "R10"; inh_prob = 40;
    for (int i = 0; i < 400; i++) begin
      mode = 2'((i / 37) % 4);
      do_tick((i % 5) != 0, (i % 29) == 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule